// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block is the transmit half of an asynchronous serial port. Software writes a byte into a one-entry holding buffer. When the shift register is free, the byte moves into it and goes out as a standard 8N1 frame: a low start bit, eight data bits with the least significant first, and a high stop bit. Bit timing comes from a one-cycle baud tick supplied by an external rate generator.

For LIN-style bus masters the block can also send a break. A pulse on the break-set input raises a request bit. If that bit is set when the next byte moves into the shift register, the frame becomes a break. A break is a start bit, twelve bit times of zero and a stop bit, and the byte's value is thrown away. The request clears itself when the break's stop bit ends. Because the holding buffer empties as soon as the break frame is loaded, the sync byte (usually 0x55) can be queued while the break is still on the line. That byte then follows as a normal frame with no idle gap.

Two flags let software pace its writes: one shows the holding buffer is empty and one shows the shift register is idle. A sticky overrun flag records a write that arrived while the buffer was full.

Top module: `break_uart_tx`

## Requirements
- R1: A normal frame drives the line low for one bit time (start), then data bits 0 through 7 in that order, then high for one bit time (stop). Each bit lasts from one baud tick to the next, and the line changes only at a cycle with a baud tick while enabled.
- R2: After a byte enters the shift register, the line stays high until the first following baud tick, and the start bit begins at that tick.
- R3: When the break request is set at the moment a byte enters the shift register, the frame is a start bit plus twelve zero bits, so the line is low for 13 bit times, followed by a high stop bit. The byte's value has no effect on the line.
- R4: A one-cycle pulse on `breakSet` sets `breakReq` in the next cycle. The bit stays set through the break frame and clears at the baud tick that ends that frame's stop bit.
- R5: `bufEmpty` goes high in the cycle after a byte moves into the shift register. A byte queued during a frame enters the shift register at the tick that ends the stop bit and starts its start bit at that same tick. A byte queued during a break is sent as a normal frame.
- R6: `shiftEmpty` is low from the cycle after a load until the tick that ends the last stop bit, and high when no frame is loaded.
- R7: A write while `bufEmpty` is low leaves the buffered byte unchanged and sets `ovrFlag` in the next cycle. `ovrFlag` stays set until a pulse on `ovrClear`.
- R8: While `txEnable` is low, no byte moves into the shift register. From the next cycle on the line is high and any frame in progress is dropped. The holding buffer keeps its byte and still accepts writes.
- R9: After synchronous reset the line is high, `bufEmpty` and `shiftEmpty` are high, and `breakReq` and `ovrFlag` are low.
- R10: A write while `bufEmpty` is high stores the byte, and `bufEmpty` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txEnable | input | 1 | Transmitter enable |
| baudTick | input | 1 | One-cycle pulse marking each bit boundary |
| wrStrobe | input | 1 | Write strobe for the holding buffer |
| wrByte | input | DATA_W | Byte to write |
| breakSet | input | 1 | Pulse that sets the break request |
| ovrClear | input | 1 | Pulse that clears the overrun flag |
| breakReq | output | 1 | Break request bit (cleared by hardware) |
| ovrFlag | output | 1 | Sticky overrun flag |
| bufEmpty | output | 1 | Holding buffer empty |
| shiftEmpty | output | 1 | Shift register idle |
| txLine | output | 1 | Serial output line |

## Verification
The assertions check these properties on every cycle:
- the line changes only on enabled baud ticks;
- the line is high while idle and right after enable drops;
- a write into an empty buffer fills it;
- the overrun flag is set by a rejected write and stays set until cleared;
- the break request clears only at a tick during a high stop bit.

Only the bench scenarios can show the bit order and frame lengths. The same holds for the zeroing of break data, the back-to-back hand-off from break to sync byte, and the proof that a rejected byte never reaches the line.

// File: rtl/bktx_pkg.sv
package bktx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_START,
    ST_DATA,
    ST_STOP
  } txState_t;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_SHIFT
  } lineSel_t;

  typedef struct packed {
    logic     holdLoad;
    logic     shiftLoad;
    logic     zeroFill;
    logic     shiftAdv;
    lineSel_t lineSel;
  } dpCtrl_t;

endpackage

// File: rtl/bktx_ctrl.sv
module bktx_ctrl
  import bktx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BRK_W  = 12
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    txEnable,
  input  logic    baudTick,
  input  logic    wrStrobe,
  input  logic    breakSet,
  input  logic    ovrClear,
  output dpCtrl_t dpCtl,
  output logic    bufEmpty,
  output logic    shiftEmpty,
  output logic    breakReq,
  output logic    ovrFlag
);

  localparam int MAX_BITS = (BRK_W > DATA_W) ? BRK_W : DATA_W;
  localparam int CNT_W    = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_BRK  = CNT_W'(BRK_W - 1);

  txState_t         state, stateNext;
  logic [CNT_W-1:0] bitCnt;
  logic             holdValid;
  logic             isBreakFrame;

  logic stopEnd, slotFree, transfer, brkClear, brkSample, wrAccept, lastBit;

  // Frame boundary and hand-off decisions
  assign stopEnd   = (state == ST_STOP) && baudTick;
  assign slotFree  = (state == ST_IDLE) || stopEnd;
  assign transfer  = txEnable && holdValid && slotFree;
  assign brkClear  = stopEnd && isBreakFrame;
  assign brkSample = breakReq && !brkClear;
  assign wrAccept  = wrStrobe && !holdValid;
  assign lastBit   = bitCnt == (isBreakFrame ? LAST_BRK : LAST_DATA);

  always_comb begin
    stateNext = state;
    if (!txEnable) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (transfer) stateNext = ST_ARMED;
        ST_ARMED: if (baudTick) stateNext = ST_START;
        ST_START: if (baudTick) stateNext = ST_DATA;
        ST_DATA:  if (baudTick && lastBit) stateNext = ST_STOP;
        ST_STOP:  if (baudTick) stateNext = transfer ? ST_START : ST_IDLE;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      bitCnt       <= '0;
      holdValid    <= 1'b0;
      isBreakFrame <= 1'b0;
      breakReq     <= 1'b0;
      ovrFlag      <= 1'b0;
    end else begin
      state <= stateNext;

      if (state == ST_START && baudTick)     bitCnt <= '0;
      else if (state == ST_DATA && baudTick) bitCnt <= bitCnt + 1'b1;

      if (wrAccept)      holdValid <= 1'b1;
      else if (transfer) holdValid <= 1'b0;

      if (transfer) isBreakFrame <= brkSample;

      if (breakSet)      breakReq <= 1'b1;
      else if (brkClear) breakReq <= 1'b0;

      if (wrStrobe && holdValid) ovrFlag <= 1'b1;
      else if (ovrClear)         ovrFlag <= 1'b0;
    end
  end

  always_comb begin
    dpCtl.holdLoad  = wrAccept;
    dpCtl.shiftLoad = transfer;
    dpCtl.zeroFill  = brkSample;
    dpCtl.shiftAdv  = (state == ST_DATA) && baudTick;
    case (state)
      ST_START: dpCtl.lineSel = LINE_SPACE;
      ST_DATA:  dpCtl.lineSel = LINE_SHIFT;
      default:  dpCtl.lineSel = LINE_MARK;
    endcase
  end

  assign bufEmpty   = !holdValid;
  assign shiftEmpty = (state == ST_IDLE);

endmodule

// File: rtl/bktx_datapath.sv
module bktx_datapath
  import bktx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           dpCtl,
  input  logic [DATA_W-1:0] wrByte,
  output logic              txLine
);

  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdData <= '0;
      shiftReg <= '0;
    end else begin
      if (dpCtl.holdLoad) holdData <= wrByte;
      if (dpCtl.shiftLoad)
        shiftReg <= dpCtl.zeroFill ? '0 : holdData;
      else if (dpCtl.shiftAdv)
        shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (dpCtl.lineSel)
      LINE_SPACE: txLine = 1'b0;
      LINE_SHIFT: txLine = shiftReg[0];
      default:    txLine = 1'b1;
    endcase
  end

endmodule

// File: rtl/break_uart_tx.sv
module break_uart_tx
  import bktx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BRK_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txEnable,
  input  logic              baudTick,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              breakSet,
  input  logic              ovrClear,
  output logic              breakReq,
  output logic              ovrFlag,
  output logic              bufEmpty,
  output logic              shiftEmpty,
  output logic              txLine
);

  dpCtrl_t dpCtl;

  bktx_ctrl #(.DATA_W(DATA_W), .BRK_W(BRK_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .txEnable   (txEnable),
    .baudTick   (baudTick),
    .wrStrobe   (wrStrobe),
    .breakSet   (breakSet),
    .ovrClear   (ovrClear),
    .dpCtl      (dpCtl),
    .bufEmpty   (bufEmpty),
    .shiftEmpty (shiftEmpty),
    .breakReq   (breakReq),
    .ovrFlag    (ovrFlag)
  );

  bktx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .dpCtl  (dpCtl),
    .wrByte (wrByte),
    .txLine (txLine)
  );

endmodule

// File: rtl/bktx_checker.sv
module bktx_checker (
  input logic clk,
  input logic rst,
  input logic txEnable,
  input logic baudTick,
  input logic wrStrobe,
  input logic ovrClear,
  input logic breakReq,
  input logic ovrFlag,
  input logic bufEmpty,
  input logic shiftEmpty,
  input logic txLine
);

  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    ($past(txEnable) && !$stable(txLine)) |-> $past(baudTick)); // R1

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    shiftEmpty |-> txLine); // R6

  AST_DISABLE_MARK: assert property (@(posedge clk) disable iff (rst)
    !txEnable |=> (txLine && shiftEmpty)); // R8

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && bufEmpty) |=> !bufEmpty); // R10

  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && !bufEmpty) |=> ovrFlag); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovrFlag && !ovrClear) |=> ovrFlag); // R7

  AST_BRK_CLEAR_AT_STOP: assert property (@(posedge clk) disable iff (rst)
    $fell(breakReq) |-> ($past(baudTick) && $past(txLine))); // R4

endmodule

bind break_uart_tx bktx_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .txEnable   (txEnable),
  .baudTick   (baudTick),
  .wrStrobe   (wrStrobe),
  .ovrClear   (ovrClear),
  .breakReq   (breakReq),
  .ovrFlag    (ovrFlag),
  .bufEmpty   (bufEmpty),
  .shiftEmpty (shiftEmpty),
  .txLine     (txLine)
);

// File: tb/break_uart_tx_test.sv
module break_uart_tx_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txEnable = 1'b0;
  logic       baudTick = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrByte = 8'h00;
  logic       breakSet = 1'b0;
  logic       ovrClear = 1'b0;
  logic       breakReq, ovrFlag, bufEmpty, shiftEmpty, txLine;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  break_uart_tx #(.DATA_W(8), .BRK_W(12)) uut (
    .clk(clk), .rst(rst), .txEnable(txEnable), .baudTick(baudTick),
    .wrStrobe(wrStrobe), .wrByte(wrByte), .breakSet(breakSet),
    .ovrClear(ovrClear), .breakReq(breakReq), .ovrFlag(ovrFlag),
    .bufEmpty(bufEmpty), .shiftEmpty(shiftEmpty), .txLine(txLine)
  );

  // Stimulus vectors: bit 8 = send as break, bits 7:0 = byte written
  localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h000, 9'h0FF, 9'h1FF, 9'h001, 9'h13C};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk) baudTick = 1'b1;
    @(negedge clk) baudTick = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk) begin wrStrobe = 1'b1; wrByte = b; end
    @(negedge clk) wrStrobe = 1'b0;
  endtask

  task automatic pulseBreak();
    @(negedge clk) breakSet = 1'b1;
    @(negedge clk) breakSet = 1'b0;
  endtask

  // Ticks through start, data bits and stop; the stop-ending tick is left to the caller
  task automatic expectFrame(input logic [7:0] data, input bit brk, input string req);
    int nBits;
    nBits = brk ? 12 : 8;
    for (int i = 0; i <= nBits + 1; i++) begin
      logic expBit;
      tick();
      if (i == 0)          expBit = 1'b0;
      else if (i > nBits)  expBit = 1'b1;
      else if (brk)        expBit = 1'b0;
      else                 expBit = data[i-1];
      check(txLine == expBit, req, int'(txLine), int'(expBit));
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(txLine == 1'b1, "R9 line", int'(txLine), 1);
    check(bufEmpty == 1'b1, "R9 bufEmpty", int'(bufEmpty), 1);
    check(shiftEmpty == 1'b1, "R9 shiftEmpty", int'(shiftEmpty), 1);
    check(breakReq == 1'b0, "R9 breakReq", int'(breakReq), 0);
    check(ovrFlag == 1'b0, "R9 ovrFlag", int'(ovrFlag), 0);

    // R8 / R10 / R7: buffer with transmitter disabled
    writeByte(8'h11);
    check(bufEmpty == 1'b0, "R10 filled", int'(bufEmpty), 0);
    tick(); tick();
    check(txLine == 1'b1, "R8 line high disabled", int'(txLine), 1);
    check(shiftEmpty == 1'b1, "R8 no load disabled", int'(shiftEmpty), 1);
    writeByte(8'h22);
    check(ovrFlag == 1'b1, "R7 overrun set", int'(ovrFlag), 1);
    @(negedge clk) txEnable = 1'b1;
    @(negedge clk);
    check(shiftEmpty == 1'b0, "R6 loaded", int'(shiftEmpty), 0);
    check(bufEmpty == 1'b1, "R5 buffer freed", int'(bufEmpty), 1);
    repeat (3) @(negedge clk);
    check(txLine == 1'b1, "R2 high before tick", int'(txLine), 1);
    expectFrame(8'h11, 1'b0, "R7 rejected byte not sent");
    tick();
    check(shiftEmpty == 1'b1, "R6 idle after stop", int'(shiftEmpty), 1);
    check(ovrFlag == 1'b1, "R7 overrun sticky", int'(ovrFlag), 1);
    @(negedge clk) ovrClear = 1'b1;
    @(negedge clk) ovrClear = 1'b0;
    check(ovrFlag == 1'b0, "R7 overrun cleared", int'(ovrFlag), 0);

    // Vector table: normal and break frames
    foreach (VEC[k]) begin
      if (VEC[k][8]) begin
        pulseBreak();
        check(breakReq == 1'b1, "R4 break set", int'(breakReq), 1);
      end
      writeByte(VEC[k][7:0]);
      @(negedge clk);
      check(bufEmpty == 1'b1 && shiftEmpty == 1'b0, "R5/R6 load",
            int'({bufEmpty, shiftEmpty}), 2);
      check(txLine == 1'b1, "R2 armed high", int'(txLine), 1);
      expectFrame(VEC[k][7:0], VEC[k][8], VEC[k][8] ? "R3 break frame" : "R1 normal frame");
      tick();
      check(shiftEmpty == 1'b1, "R6 frame done", int'(shiftEmpty), 1);
      check(breakReq == 1'b0, "R4 break cleared", int'(breakReq), 0);
    end

    // Break followed by queued sync byte
    pulseBreak();
    writeByte(8'hA3);
    @(negedge clk);
    writeByte(8'h55);
    check(bufEmpty == 1'b0, "R5 sync queued", int'(bufEmpty), 0);
    expectFrame(8'hA3, 1'b1, "R3 break before sync");
    check(breakReq == 1'b1, "R4 held through stop", int'(breakReq), 1);
    tick();
    check(txLine == 1'b0, "R5 sync start no gap", int'(txLine), 0);
    check(breakReq == 1'b0, "R4 auto-clear", int'(breakReq), 0);
    check(bufEmpty == 1'b1, "R5 buffer free", int'(bufEmpty), 1);
    for (int i = 0; i < 9; i++) begin
      logic expBit;
      tick();
      expBit = (i < 8) ? 8'h55 >> i : 1'b1;
      check(txLine == expBit, "R5 sync sent normal", int'(txLine), int'(expBit));
    end
    tick();
    check(shiftEmpty == 1'b1, "R6 idle after sync", int'(shiftEmpty), 1);

    // R8 abort in flight
    writeByte(8'hF0);
    @(negedge clk);
    tick(); tick();
    check(txLine == 1'b0, "R8 mid-frame low", int'(txLine), 0);
    @(negedge clk) txEnable = 1'b0;
    @(negedge clk);
    check(txLine == 1'b1 && shiftEmpty == 1'b1, "R8 abort",
          int'({txLine, shiftEmpty}), 3);
    @(negedge clk) txEnable = 1'b1;
    tick(); tick();
    check(shiftEmpty == 1'b1 && txLine == 1'b1, "R8 stays idle",
          int'({shiftEmpty, txLine}), 3);

    finish();
  end

endmodule